// File: doc/BRIEF.md
# Quadrature and Up/Down Position Counter

This block keeps a wide signed-agnostic position count driven by two external inputs, A and B. A two-bit mode select picks how the pair is read. In the two code-following modes the pair is treated as a 2-bit position code, either in Gray order, as a quadrature encoder emits, or in plain binary order. Every legal one-step change of that code moves the count by one, so a full quadrature cycle gives four counts. In the two pulse modes, rising edges are counted instead. In one of them a level on B chooses the direction. In the other, A counts up and B counts down.

Both inputs are asynchronous to the system clock and pass through a synchronizer chain before any decode. A load strobe writes an arbitrary value into the count, and loading zero clears it. The load also clears a sticky flag. That flag records a code jump of two steps, which cannot be given a direction and so is not counted. The count wraps modulo 2^CNT_W in both directions.

Top module: `pos_counter`

## Requirements
- R1: While reset is applied and after reset is released, `count` reads 0 and `step_err` reads 0 until an input change or a load occurs.
- R2: A cycle with `load_en` high writes `load_val` into `count` at that clock edge and clears `step_err`. The load takes priority over any step decoded in the same cycle.
- R3: With `mode` = 0 (Gray code), the code {in_b,in_a} is mapped to a position: 00→0, 01→1, 11→2, 10→3. A change to the next position (mod 4) adds one to `count`, and a change to the previous position subtracts one.
- R4: With `mode` = 1 (binary code), the code {in_b,in_a} is taken as the number 0..3. A change of +1 mod 4 adds one to `count`, and a change of −1 mod 4 subtracts one.
- R5: In modes 0 and 1, a change of two positions leaves `count` unchanged and sets `step_err`. `step_err` stays set, through later valid steps, until a load.
- R6: With `mode` = 2 (direction level), each rising edge of in_a adds one to `count` when in_b is low and subtracts one when in_b is high. Falling edges of in_a and any change of in_b alone leave `count` unchanged.
- R7: With `mode` = 3 (separate up/down), a rising edge of in_a adds one and a rising edge of in_b subtracts one. When both rise in the same cycle, `count` is unchanged. Falling edges are ignored.
- R8: The count wraps: one step up from all ones gives 0, and one step down from 0 gives all ones.
- R9: With the default two synchronizer stages, an input change set up before clock edge E1 leaves `count` unchanged after edge E2 and shows its effect after edge E3.
- R10: Changing `mode` while the inputs are static does not change `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_a | input | 1 | Asynchronous input A (code bit 0, count pulse or up pulse) |
| in_b | input | 1 | Asynchronous input B (code bit 1, direction level or down pulse) |
| mode | input | 2 | 0 Gray code, 1 binary code, 2 direction level, 3 separate up/down |
| load_en | input | 1 | Load strobe: writes `load_val` and clears `step_err` |
| load_val | input | CNT_W | Value written on a load |
| count | output | CNT_W | Current position count |
| step_err | output | 1 | Sticky flag for a two-position code jump |

## Verification
The bench covers every old-to-new input pair in all four modes. It computes the expected count and flag arithmetically from the position mapping. This catches a design that swaps the Gray order for the binary one, counts a two-position jump in either direction, or counts falling edges. It also drives simultaneous rising edges in the up/down mode, where a design that lets one input win would move the count. The wrap points in both directions, a load landing in the same cycle as a decoded step, and the exact edge at which a change emerges from the synchronizer are each probed. A wrong priority shows up as a count one away from the loaded value, and a missing or extra stage shows up as a count that changes one edge early or late. Mode changes under static inputs are checked for spurious counts.

// File: rtl/pos_cnt_pkg.sv
package pos_cnt_pkg;

  typedef enum logic [1:0] {
    MODE_GRAY   = 2'd0,
    MODE_BINARY = 2'd1,
    MODE_DIRLVL = 2'd2,
    MODE_UPDOWN = 2'd3
  } cnt_mode_e;

  // Map a 2-bit input code {b,a} to a position 0..3 for the code modes.
  function automatic logic [1:0] code_to_pos(input cnt_mode_e m, input logic [1:0] c);
    logic [1:0] p;
    if (m == MODE_GRAY) p = {c[1], c[1] ^ c[0]};
    else                p = c;
    return p;
  endfunction

endpackage

// File: rtl/pos_rst_sync.sv
module pos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= 1'b1;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pos_in_sync.sv
module pos_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pos_step_decode.sv
module pos_step_decode
  import pos_cnt_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] cur,   // {b,a} after synchronizer
  input  logic [1:0] prv,   // {b,a} one cycle earlier
  output logic       step_up,
  output logic       step_dn,
  output logic       step_bad
);
  cnt_mode_e  m;
  logic [1:0] pos_new;
  logic [1:0] pos_old;
  logic [1:0] delta;
  logic       rise_a;
  logic       rise_b;

  always_comb begin
    m        = cnt_mode_e'(mode);
    pos_new  = code_to_pos(m, cur);
    pos_old  = code_to_pos(m, prv);
    delta    = pos_new - pos_old;
    rise_a   = cur[0] & ~prv[0];
    rise_b   = cur[1] & ~prv[1];
    step_up  = 1'b0;
    step_dn  = 1'b0;
    step_bad = 1'b0;
    unique case (m)
      MODE_GRAY, MODE_BINARY: begin
        step_up  = (delta == 2'd1);
        step_dn  = (delta == 2'd3);
        step_bad = (delta == 2'd2);
      end
      MODE_DIRLVL: begin
        step_up = rise_a & ~cur[1];
        step_dn = rise_a &  cur[1];
      end
      MODE_UPDOWN: begin
        step_up = rise_a & ~rise_b;
        step_dn = rise_b & ~rise_a;
      end
      default: begin
        step_up = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pos_count_core.sv
module pos_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             step_bad,
  output logic [CNT_W-1:0] count,
  output logic             step_err
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;
  logic             err_en;

  // next-state
  always_comb begin
    cnt_en = load_en | step_up | step_dn;
    if (load_en)      cnt_d = load_val;
    else if (step_up) cnt_d = cnt_q + ONE;
    else if (step_dn) cnt_d = cnt_q - ONE;
    else              cnt_d = cnt_q;

    err_en = load_en | step_bad;
    err_d  = load_en ? 1'b0 : 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign count    = cnt_q;
  assign step_err = err_q;
endmodule

// File: rtl/pos_counter.sv
module pos_counter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic [1:0]       mode,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             step_err
);
  logic       rst_i_n;
  logic [1:0] pins_s;
  logic [1:0] prv_q;
  logic       dec_up;
  logic       dec_dn;
  logic       dec_bad;

  pos_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pos_in_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({in_b, in_a}),
    .q     (pins_s)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) prv_q <= 2'b00;
    else          prv_q <= pins_s;
  end

  pos_step_decode u_dec (
    .mode     (mode),
    .cur      (pins_s),
    .prv      (prv_q),
    .step_up  (dec_up),
    .step_dn  (dec_dn),
    .step_bad (dec_bad)
  );

  pos_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (load_en),
    .load_val (load_val),
    .step_up  (dec_up),
    .step_dn  (dec_dn),
    .step_bad (dec_bad),
    .count    (count),
    .step_err (step_err)
  );
endmodule

// File: rtl/pos_counter_chk.sv
module pos_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count,
  input logic             step_err,
  input logic             up,
  input logic             dn,
  input logic             bad
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count == $past(load_val));

  // R2
  load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !step_err);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_err && !load_en) |=> step_err);

  // R5
  jump_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !load_en) |=> (count == $past(count)) && step_err);

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up, dn, bad}));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !load_en) |=> count == $past(count) + ONE);

  // R3
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !load_en) |=> count == $past(count) - ONE);

  // R8
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !load_en && count == '1) |=> count == '0);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !up && !dn) |=> $stable(count));
endmodule

bind pos_counter pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .load_en  (load_en),
  .load_val (load_val),
  .count    (count),
  .step_err (step_err),
  .up       (dec_up),
  .dn       (dec_dn),
  .bad      (dec_bad)
);

// File: tb/sim_pos_counter.sv
`timescale 1ns/1ps
module sim_pos_counter;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         in_a, in_b;
  logic [1:0]   mode;
  logic         load_en;
  logic [W-1:0] load_val;
  logic [W-1:0] count;
  logic         step_err;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  pos_counter #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .mode(mode),
    .load_en(load_en), .load_val(load_val), .count(count), .step_err(step_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_val = v;
    load_en  = 1'b1;
    cyc(1);
    load_en  = 1'b0;
  endtask

  task automatic set_in(input logic [1:0] c);
    in_b = c[1];
    in_a = c[0];
    cyc(4);
  endtask

  function automatic logic [1:0] pos_of(input int m, input logic [1:0] c);
    if (m == 0) return {c[1], c[1] ^ c[0]};
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] base;
    logic [W-1:0] exp;
    rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0; mode = 2'd0;
    load_en = 1'b0; load_val = '0;
    cyc(3);
    check("R1 count in reset", count, '0);
    check("R1 flag in reset", {31'b0, step_err}, '0);
    rst_n = 1'b1;
    cyc(6);
    check("R1 count after reset", count, '0);
    check("R1 flag after reset", {31'b0, step_err}, '0);

    // R3 R4 R5: all code transitions in both code modes
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 4; o++) begin
        for (int n = 0; n < 4; n++) begin
          logic [1:0] d;
          base = 32'h8000_0000 + 32'(o * 4 + n);
          mode = 2'(m);
          set_in(2'(o));
          do_load(base);
          set_in(2'(n));
          d = pos_of(m, 2'(n)) - pos_of(m, 2'(o));
          exp = (d == 2'd1) ? base + 1 : (d == 2'd3) ? base - 1 : base;
          check(m == 0 ? "R3 gray step" : "R4 binary step", count, exp);
          check("R5 jump flag", {31'b0, step_err}, {31'b0, d == 2'd2});
        end
      end
    end

    // R6: direction level mode
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] oc, nc;
        oc = 2'(o); nc = 2'(n);
        base = 32'h0000_1000;
        mode = 2'd2;
        set_in(oc);
        do_load(base);
        set_in(nc);
        exp = (!oc[0] && nc[0]) ? (nc[1] ? base - 1 : base + 1) : base;
        check("R6 direction level", count, exp);
      end
    end

    // R7: separate up/down mode, including simultaneous rises
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] oc, nc;
        oc = 2'(o); nc = 2'(n);
        base = 32'h0000_2000;
        mode = 2'd3;
        set_in(oc);
        do_load(base);
        set_in(nc);
        exp = base + ((!oc[0] && nc[0]) ? 1 : 0) - ((!oc[1] && nc[1]) ? 1 : 0);
        check("R7 up/down edges", count, exp);
      end
    end

    // R8: wrap both ways
    mode = 2'd0;
    set_in(2'b00);
    do_load('1);
    set_in(2'b01);
    check("R8 wrap up", count, '0);
    set_in(2'b00);
    check("R8 wrap down", count, '1);

    // R3: long forward then backward walk
    do_load('0);
    for (int i = 0; i < 8; i++) set_in((i % 4 == 0) ? 2'b01 : (i % 4 == 1) ? 2'b11 : (i % 4 == 2) ? 2'b10 : 2'b00);
    check("R3 forward walk", count, 32'd8);
    set_in(2'b10); set_in(2'b11); set_in(2'b01); set_in(2'b00);
    check("R3 backward walk", count, 32'd4);

    // R5: flag stays through a valid step, load clears it
    set_in(2'b11);
    check("R5 jump count", count, 32'd4);
    set_in(2'b10);
    check("R5 step after jump", count, 32'd5);
    check("R5 flag sticky", {31'b0, step_err}, 32'd1);
    do_load(32'd0);
    check("R2 load clears flag", {31'b0, step_err}, 32'd0);

    // R9: latency through synchronizer
    mode = 2'd3;
    set_in(2'b00);
    do_load(32'd100);
    in_a = 1'b1;
    cyc(2);
    check("R9 no change after E2", count, 32'd100);
    cyc(1);
    check("R9 change after E3", count, 32'd101);

    // R2: load wins over a step in the same cycle
    in_a = 1'b0;
    cyc(4);
    do_load(32'd50);
    in_b = 1'b1;
    cyc(2);
    load_val = 32'd7;
    load_en  = 1'b1;
    cyc(1);
    load_en  = 1'b0;
    check("R2 load priority", count, 32'd7);
    cyc(3);
    check("R2 held after load", count, 32'd7);

    // R10: mode changes with static inputs
    set_in(2'b11);
    do_load(32'd9);
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      cyc(4);
      check("R10 mode switch", count, 32'd9);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule